// File: doc/BRIEF.md
# Replicated Descriptor Fill Engine

This block stores one translation descriptor into table memory for software. A command gives a table base, a virtual address, a level flag and the descriptor word. The engine works out which table entry covers the address and issues word writes on a memory port that has a ready handshake.

Some descriptors map a block wider than the span of one entry. These are a supersection at the first level and a 64KB page at the second level. The low four index bits of the address can then take any of their sixteen values for the same mapping. For such a descriptor the engine clears those four index bits and writes the same word into sixteen consecutive entries. Every other descriptor is written once. A one-cycle done pulse marks the end of each command, and the engine drops any command that arrives while it is working.

The controller has three states. IDLE waits for a command. WRITE presents one copy and holds it until the port accepts it. DONE raises the completion pulse. The transitions are: IDLE to WRITE when a command arrives (cmd_take); WRITE to WRITE when a copy that is not the last is accepted (copy_next); WRITE to DONE when the last copy is accepted (copy_last); DONE to IDLE always (finish).

Top module: `desc_fill_engine`

## Requirements
- R1: With cmd_level=0 (first level), the entry address is {cmd_base[31:14], cmd_vaddr[31:20], 2'b00}.
- R2: With cmd_level=1 (second level), the entry address is {cmd_base[31:10], cmd_vaddr[19:12], 2'b00}.
- R3: A descriptor is replicated when either of these holds: cmd_level=0, desc[1:0]=2'b10 and desc[18]=1; or cmd_level=1 and desc[1:0]=2'b01. A replicated descriptor gives exactly 16 writes with identical data. The first write goes to the entry whose low four index bits are cleared, and each later address is 4 bytes above the one before.
- R4: Any other descriptor gives exactly one write, to the unaligned entry address of R1 or R2. This covers a first-level section with desc[18]=0, a fault type and the second-level small page types.
- R5: While wr_valid is high and wr_ready is low, wr_addr and wr_data hold their values. The next copy appears only after the current one has been accepted.
- R6: done is high for exactly one cycle. That cycle directly follows the clock edge at which the last write is accepted, and wr_valid is low during it.
- R7: cmd_valid is ignored from the edge that takes a command through the done cycle. A command held during that time causes no extra write.
- R8: After reset, wr_valid and done are low.
- R9: A command taken in IDLE presents its first write in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only in IDLE |
| cmd_base | input | 32 | Table base byte address |
| cmd_vaddr | input | 32 | Virtual address being mapped |
| cmd_level | input | 1 | 0 = first-level table, 1 = second-level table |
| cmd_desc | input | 32 | Descriptor word to store |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Memory accepts the write at this edge |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the last copy being accepted, and a new command being presented. The DONE cycle can also coincide with a command that is still held high. The bench provokes both by holding a different command on cmd_valid for the whole time a fill runs, including the done cycle. It stalls the port with random wr_ready so that the final acceptance lands on varying cycles. The result is judged at the ports: the expected address sequence must end exactly on the predicted count, done must rise once, and no further write may follow before the held command is withdrawn.

// File: rtl/desc_fill_pkg.sv
package desc_fill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } fill_state_e;

    // Descriptor type codes in bits [1:0]
    localparam logic [1:0] TYPE_L1_SECTION = 2'b10;
    localparam logic [1:0] TYPE_L2_LARGE   = 2'b01;
    // Bit that marks a first-level section as a supersection
    localparam int SUPER_BIT = 18;

endpackage

// File: rtl/desc_fill_addr.sv
module desc_fill_addr
    import desc_fill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int L1_IDX_W   = 12,
    parameter int L2_IDX_W   = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int REP_LOG2   = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              level,
    input  logic [DATA_W-1:0] desc,
    output logic [ADDR_W-1:0] start_addr,
    output logic              replicate
);
    localparam int L1_TBL_SHIFT = L1_IDX_W + 2;
    localparam int L2_TBL_SHIFT = L2_IDX_W + 2;

    logic [L1_IDX_W-1:0] l1_idx;
    logic [L2_IDX_W-1:0] l2_idx;
    logic [L1_IDX_W-1:0] l1_idx_use;
    logic [L2_IDX_W-1:0] l2_idx_use;

    always_comb begin
        l1_idx = vaddr[ADDR_W-1 -: L1_IDX_W];
        l2_idx = vaddr[PAGE_SHIFT +: L2_IDX_W];

        if (level == 1'b0)
            replicate = (desc[1:0] == TYPE_L1_SECTION) && desc[SUPER_BIT];
        else
            replicate = (desc[1:0] == TYPE_L2_LARGE);

        l1_idx_use = l1_idx;
        l2_idx_use = l2_idx;
        if (replicate) begin
            l1_idx_use[REP_LOG2-1:0] = '0;
            l2_idx_use[REP_LOG2-1:0] = '0;
        end

        if (level == 1'b0)
            start_addr = {base[ADDR_W-1:L1_TBL_SHIFT], l1_idx_use, 2'b00};
        else
            start_addr = {base[ADDR_W-1:L2_TBL_SHIFT], l2_idx_use, 2'b00};
    end

endmodule

// File: rtl/desc_fill_seq.sv
module desc_fill_seq
    import desc_fill_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int REP_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              replicate,
    input  logic [DATA_W-1:0] desc,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    localparam logic [REP_LOG2-1:0] LAST_CNT = '1;
    localparam logic [ADDR_W-1:0]   WORD_STEP = ADDR_W'(4);

    fill_state_e state_q, state_d;
    logic [REP_LOG2-1:0] left_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic cmd_take, copy_next, copy_last;

    assign cmd_take  = (state_q == ST_IDLE) && cmd_valid;
    assign copy_next = (state_q == ST_WRITE) && wr_ready && (left_q != '0);
    assign copy_last = (state_q == ST_WRITE) && wr_ready && (left_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_take)  state_d = ST_WRITE;
            ST_WRITE: if (copy_last) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_valid = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: wr_valid = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  ;
        endcase
        wr_addr = addr_q;
        wr_data = data_q;
    end

    // Copy counter and address walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (cmd_take) begin
            left_q <= replicate ? LAST_CNT : '0;
            addr_q <= start_addr;
            data_q <= desc;
        end else if (copy_next) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + WORD_STEP;
        end
    end

endmodule

// File: rtl/desc_fill_engine.sv
module desc_fill_engine
    import desc_fill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int L1_IDX_W   = 12,
    parameter int L2_IDX_W   = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int REP_LOG2   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_vaddr,
    input  logic              cmd_level,
    input  logic [DATA_W-1:0] cmd_desc,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              done
);
    logic [ADDR_W-1:0] start_addr;
    logic              replicate;

    desc_fill_addr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .L1_IDX_W(L1_IDX_W),
        .L2_IDX_W(L2_IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .REP_LOG2(REP_LOG2)
    ) u_addr (
        .base(cmd_base), .vaddr(cmd_vaddr), .level(cmd_level),
        .desc(cmd_desc), .start_addr(start_addr), .replicate(replicate)
    );

    desc_fill_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REP_LOG2(REP_LOG2)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .start_addr(start_addr), .replicate(replicate), .desc(cmd_desc),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

endmodule

// File: rtl/desc_fill_checker.sv
module desc_fill_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ready,
    input logic              done
);
    a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r3_step_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=>
            (!wr_valid || (wr_addr == $past(wr_addr) + ADDR_W'(4) && $stable(wr_data))));

    a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ready));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid);

    a_r7_no_take_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_valid);

endmodule

bind desc_fill_engine desc_fill_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .done(done)
);

// File: tb/desc_fill_engine_bench.sv
`timescale 1ns/1ps
module desc_fill_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [31:0] cmd_vaddr = '0;
    logic        cmd_level = 1'b0;
    logic [31:0] cmd_desc = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b0;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    desc_fill_engine u_desc_fill_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
        .cmd_vaddr(cmd_vaddr), .cmd_level(cmd_level), .cmd_desc(cmd_desc),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .done(done)
    );

    function automatic bit exp_rep(input logic lvl, input logic [31:0] d);
        if (!lvl) return (d[1:0] == 2'b10) && d[18];
        return d[1:0] == 2'b01;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [31:0] va,
                                             input logic lvl, input bit rep, input int k);
        logic [11:0] i1;
        logic [7:0]  i2;
        i1 = va[31:20];
        i2 = va[19:12];
        if (rep) begin
            i1[3:0] = 4'd0;
            i2[3:0] = 4'd0;
        end
        i1 = i1 + 12'(k);
        i2 = i2 + 8'(k);
        if (!lvl) return {b[31:14], i1, 2'b00};
        return {b[31:10], i2, 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // rmode: 0 = always ready, 1 = random stalls. noise: hold another command while busy.
    task automatic run_cmd(input logic [31:0] b, input logic [31:0] va, input logic lvl,
                           input logic [31:0] d, input bit rmode, input bit noise);
        bit rep;
        int n;
        int k;
        rep = exp_rep(lvl, d);
        n = rep ? 16 : 1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_base = b; cmd_vaddr = va; cmd_level = lvl; cmd_desc = d;
        wr_ready = 1'b0;
        k = 0;
        @(negedge clk);
        check(wr_valid === 1'b1, "R9 first write next cycle", 32'(wr_valid), 32'd1);
        if (noise) begin
            cmd_base = ~b; cmd_vaddr = va ^ 32'h00F0_F000; cmd_level = ~lvl;
            cmd_desc = d ^ 32'h0004_0003;
        end else begin
            cmd_valid = 1'b0;
        end
        while (k < n) begin
            check(wr_valid === 1'b1, rep ? "R3 write valid" : "R4 write valid",
                  32'(wr_valid), 32'd1);
            check(wr_addr === exp_addr(b, va, lvl, rep, k),
                  lvl ? "R2/R3/R4 L2 address" : "R1/R3/R4 L1 address",
                  wr_addr, exp_addr(b, va, lvl, rep, k));
            check(wr_data === d, "R3 replicated data", wr_data, d);
            check(done === 1'b0, "R6 no early done", 32'(done), 32'd0);
            wr_ready = rmode ? 1'($urandom % 2) : 1'b1;
            if (wr_ready) k++;
            else begin
                @(negedge clk);
                check(wr_addr === exp_addr(b, va, lvl, rep, k), "R5 held under stall",
                      wr_addr, exp_addr(b, va, lvl, rep, k));
                wr_ready = 1'b0;
                continue;
            end
            @(negedge clk);
            wr_ready = 1'b0;
        end
        check(done === 1'b1, "R6 done after last accept", 32'(done), 32'd1);
        check(wr_valid === 1'b0, rep ? "R3 exactly 16 writes" : "R4 exactly one write",
              32'(wr_valid), 32'd0);
        @(negedge clk);
        check(done === 1'b0, "R6 single-cycle done", 32'(done), 32'd0);
        check(wr_valid === 1'b0, "R7 held command ignored", 32'(wr_valid), 32'd0);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(wr_valid === 1'b0, "R7 nothing after withdraw", 32'(wr_valid), 32'd0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(wr_valid === 1'b0, "R8 reset wr_valid", 32'(wr_valid), 32'd0);
        check(done === 1'b0, "R8 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        // Directed corners
        run_cmd(32'h1234_8000, 32'hABC7_1234, 1'b0, 32'h0104_0C02, 1'b0, 1'b0); // R3 L1 super
        run_cmd(32'h1234_8000, 32'hABC7_1234, 1'b0, 32'h0100_0C02, 1'b0, 1'b0); // R4 L1 section
        run_cmd(32'h0000_4000, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b1, 1'b1); // R3 top index
        run_cmd(32'h8765_4C00, 32'h0003_B000, 1'b1, 32'h5555_0001, 1'b1, 1'b1); // R3 L2 large
        run_cmd(32'h8765_4C00, 32'h0003_B000, 1'b1, 32'h5555_0002, 1'b0, 1'b1); // R4 L2 small
        run_cmd(32'h8765_4C00, 32'h000F_F000, 1'b1, 32'h5555_0003, 1'b0, 1'b0); // R2 R4
        run_cmd(32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1, 1'b0); // R4 fault
        run_cmd(32'h0000_0000, 32'h0123_4567, 1'b0, 32'h0004_0001, 1'b0, 1'b0); // R1 R4
        // Constrained random
        for (int i = 0; i < 60; i++) begin
            logic [31:0] d;
            d = $urandom;
            if (($urandom % 3) == 0) begin
                d[18] = 1'b1;
                d[1:0] = 2'b10;
            end
            run_cmd($urandom, $urandom, 1'($urandom % 2), d,
                    1'($urandom % 2), 1'($urandom % 2));
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule